// File: doc/BRIEF.md
# Per-Line Interrupt Trigger Conditioner

This block turns a vector of synchronous interrupt request lines into a registered pending vector, one bit per line. Each line has its own three-bit sensing configuration: one bit picks level sensing or edge sensing, one bit selects both-edge sensing, and one polarity bit picks active-high or rising (1) versus active-low or falling (0). The block keeps a registered copy of every line's level from the previous clock so that it can detect transitions.

A level-sensed pending bit follows its line, inverted when the line is active-low, one clock after the line is sampled. An edge-sensed pending bit is set by a qualifying transition and stays set until a one is driven on that line's bit of the clear vector. A clear has no effect on level-sensed lines. If a clear and a new edge arrive on the same line in the same cycle, the bit stays set. The lines, the configuration vectors and the clear vector are plain per-cycle inputs with no handshake. The lines are assumed to be already synchronous to `clk`. The package also provides the power-up configuration vectors that a neighbouring register block loads.

Top module: `irq_trig_cond`

## Requirements
- R1: With level sensing (`sense_lvl`=1) and polarity 1, `pend` bit equals the line value sampled at the previous rising clock edge.
- R2: With level sensing and polarity 0, `pend` bit equals the inverse of the line value sampled at the previous rising edge.
- R3: With edge sensing (`sense_lvl`=0), `dual_edge`=0 and polarity 1, a 0-to-1 change between the stored previous level and the current line sets the `pend` bit at the next edge, and a 1-to-0 change does not.
- R4: With edge sensing, `dual_edge`=0 and polarity 0, a 1-to-0 change sets the `pend` bit, and a 0-to-1 change does not.
- R5: With edge sensing and `dual_edge`=1, any change of the line sets the `pend` bit, whatever the polarity bit is.
- R6: An edge-sensed `pend` bit stays set when its line returns to its earlier level.
- R7: A 1 on `edge_clr` for an edge-sensed line with no new edge clears its `pend` bit at the next edge.
- R8: `edge_clr` has no effect on a level-sensed line.
- R9: When a clear and a qualifying edge hit the same edge-sensed line in the same cycle, the `pend` bit is set after that edge.
- R10: The stored previous level of every line is updated every cycle in every mode. A line held high under level sensing and then switched to rising-edge sensing therefore sets no pending bit.
- R11: While `rst_n` is low, `pend` is all zero and every stored previous level is 0. A line that is already high in rising-edge mode at the first clock after reset therefore sets its bit.
- R12: Each line is evaluated independently: lines in different modes in the same cycle do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | Synchronous interrupt request lines |
| sense_lvl | input | N_LINES | 1 = level sensing, 0 = edge sensing |
| dual_edge | input | N_LINES | 1 = both-edge sensing (edge mode only) |
| polarity | input | N_LINES | 1 = active-high or rising, 0 = active-low or falling |
| edge_clr | input | N_LINES | Per-line clear of edge-captured pending bits |
| pend | output | N_LINES | Registered pending vector |

## Verification
The assertions check the following on every cycle against the previous cycle's inputs:
- level-sensed bits follow their line;
- the history register tracks the lines;
- edge-sensed bits never rise without a detected transition and never fall without a clear;
- a detected transition always leaves its bit set, even under a clear.

Some behaviour shows only over a sequence of cycles, so only the directed scenarios can show it:
- which transition each single-edge polarity accepts;
- that both-edge mode ignores polarity;
- that no spurious edge appears after a switch from level to edge sensing;
- the first-cycle edge after reset.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int unsigned DEF_LINES = 51;

  // power-up configuration vectors for a neighbouring register block
  localparam logic [63:0] PWRUP_SENSE_LVL = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] PWRUP_DUAL_EDGE = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] PWRUP_POLARITY  = 64'h0000_5F07_FFF8_FFFF;

  typedef enum logic [2:0] {
    TRIG_LVL_HI,
    TRIG_LVL_LO,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH
  } trig_mode_e;

  function automatic trig_mode_e trig_decode(input logic lvl, input logic dual,
                                             input logic pol);
    if (lvl)       return pol ? TRIG_LVL_HI : TRIG_LVL_LO;
    else if (dual) return TRIG_BOTH;
    else           return pol ? TRIG_RISE : TRIG_FALL;
  endfunction

endpackage

// File: rtl/irq_trig_hist.sv
module irq_trig_hist #(
  parameter int unsigned N_LINES = irq_trig_pkg::DEF_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  output logic [N_LINES-1:0] prev_lvl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= '0;
    else        prev_lvl <= line_in;
  end

  // history follows the lines in every mode
  p_hist_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (prev_lvl == $past(line_in)));

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
  parameter int unsigned N_LINES = irq_trig_pkg::DEF_LINES
) (
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] prev_lvl,
  input  logic [N_LINES-1:0] sense_lvl,
  input  logic [N_LINES-1:0] dual_edge,
  input  logic [N_LINES-1:0] polarity,
  output logic [N_LINES-1:0] is_level,
  output logic [N_LINES-1:0] level_val,
  output logic [N_LINES-1:0] edge_hit
);
  import irq_trig_pkg::*;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    trig_mode_e mode;
    always_comb begin
      mode         = trig_decode(sense_lvl[i], dual_edge[i], polarity[i]);
      is_level[i]  = 1'b0;
      level_val[i] = 1'b0;
      edge_hit[i]  = 1'b0;
      unique case (mode)
        TRIG_LVL_HI: begin is_level[i] = 1'b1; level_val[i] = line_in[i];  end
        TRIG_LVL_LO: begin is_level[i] = 1'b1; level_val[i] = ~line_in[i]; end
        TRIG_RISE:   edge_hit[i] = line_in[i] & ~prev_lvl[i];
        TRIG_FALL:   edge_hit[i] = ~line_in[i] & prev_lvl[i];
        TRIG_BOTH:   edge_hit[i] = line_in[i] ^ prev_lvl[i];
        default:     edge_hit[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/irq_trig_pend.sv
module irq_trig_pend #(
  parameter int unsigned N_LINES = irq_trig_pkg::DEF_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] is_level,
  input  logic [N_LINES-1:0] level_val,
  input  logic [N_LINES-1:0] edge_hit,
  input  logic [N_LINES-1:0] edge_clr,
  output logic [N_LINES-1:0] pend
);

  logic [N_LINES-1:0] pend_nxt;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      if (is_level[i]) pend_nxt[i] = level_val[i];
      else             pend_nxt[i] = (pend[i] & ~edge_clr[i]) | edge_hit[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end

  // edge bits rise only on a detected transition
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(is_level) & ~$past(edge_hit)) == '0));

  // edge bits fall only under a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend) & ~pend & ~$past(is_level) & ~$past(edge_clr)) == '0));

  // a clear with no new edge empties the bit
  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & $past(edge_clr & ~is_level & ~edge_hit)) == '0));

  // a detected edge wins over a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(edge_hit & ~is_level) & ~pend) == '0));

endmodule

// File: rtl/irq_trig_cond.sv
module irq_trig_cond #(
  parameter int unsigned N_LINES = irq_trig_pkg::DEF_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] sense_lvl,
  input  logic [N_LINES-1:0] dual_edge,
  input  logic [N_LINES-1:0] polarity,
  input  logic [N_LINES-1:0] edge_clr,
  output logic [N_LINES-1:0] pend
);

  logic [N_LINES-1:0] prev_lvl;
  logic [N_LINES-1:0] is_level;
  logic [N_LINES-1:0] level_val;
  logic [N_LINES-1:0] edge_hit;

  irq_trig_hist #(.N_LINES(N_LINES)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .prev_lvl (prev_lvl)
  );

  irq_trig_detect #(.N_LINES(N_LINES)) u_detect (
    .line_in   (line_in),
    .prev_lvl  (prev_lvl),
    .sense_lvl (sense_lvl),
    .dual_edge (dual_edge),
    .polarity  (polarity),
    .is_level  (is_level),
    .level_val (level_val),
    .edge_hit  (edge_hit)
  );

  irq_trig_pend #(.N_LINES(N_LINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_level  (is_level),
    .level_val (level_val),
    .edge_hit  (edge_hit),
    .edge_clr  (edge_clr),
    .pend      (pend)
  );

  // level-sensed outputs track the line of the previous cycle (clear ignored)
  p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pend ^ $past(~(line_in ^ polarity))) & $past(sense_lvl)) == '0));

  // reset value of the pending vector
  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |-> (pend == '0));

endmodule

// File: tb/irq_trig_cond_tb_top.sv
module irq_trig_cond_tb_top;
  localparam int W = 51;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] line_in = '0, sense_lvl = '0, dual_edge = '0, polarity = '0, edge_clr = '0;
  logic [W-1:0] pend;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_trig_cond #(.N_LINES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .sense_lvl(sense_lvl),
    .dual_edge(dual_edge), .polarity(polarity), .edge_clr(edge_clr), .pend(pend)
  );

  function automatic logic [W-1:0] b(input int k);
    return W'(1) << k;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] exp);
    total++;
    if (pend !== exp) begin
      bad++;
      $display("FAIL %s: pend=%h expected=%h", req, pend, exp);
    end
  endtask

  task automatic t_reset();
    sense_lvl = '0; dual_edge = '0; polarity = '1; line_in = b(3);
    repeat (3) @(negedge clk);
    chk("R11 reset", '0);
    rst_n = 1'b1;
    tick();
    chk("R11 first edge", b(3));
    edge_clr = '1; line_in = '0; tick();
    chk("R7 clear all", '0);
    edge_clr = '0;
  endtask

  task automatic t_level();
    logic [W-1:0] pol = W'(8'hFF);
    sense_lvl = '1; dual_edge = '0; polarity = pol;
    line_in = '0; tick();
    chk("R1 R2 lines low", ~pol);
    line_in = W'(8'h5A) | b(40); tick();
    chk("R1 R2 mixed", (line_in & pol) | (~line_in & ~pol));
    edge_clr = '1; tick();
    chk("R8 clear ignored", (line_in & pol) | (~line_in & ~pol));
    edge_clr = '0;
  endtask

  task automatic t_rise();
    sense_lvl = '0; dual_edge = '0; polarity = '1;
    line_in = '0; edge_clr = '1; tick();
    chk("R3 setup", '0);
    edge_clr = '0; line_in = b(0) | b(50); tick();
    chk("R3 rising", b(0) | b(50));
    line_in = '0; tick();
    chk("R3 R6 fall kept", b(0) | b(50));
    edge_clr = b(0); tick();
    chk("R7 single clear", b(50));
    edge_clr = '0;
  endtask

  task automatic t_fall();
    polarity = '0;
    line_in = '1; edge_clr = '1; tick();
    chk("R4 rise ignored", '0);
    edge_clr = '0; line_in = ~b(7); tick();
    chk("R4 falling", b(7));
  endtask

  task automatic t_both();
    dual_edge = '1; polarity = W'(32'hFFFF_FFFF);
    edge_clr = '1; tick();
    chk("R5 setup", '0);
    edge_clr = '0; line_in = (line_in & ~b(2) & ~b(40)) | b(7); tick();
    chk("R5 both edges", b(2) | b(7) | b(40));
    dual_edge = '0;
  endtask

  task automatic t_prio();
    polarity = '1; line_in = '0; edge_clr = '1; tick();
    chk("R9 setup", '0);
    line_in = b(5); edge_clr = b(5); tick();
    chk("R9 set wins", b(5));
    tick();
    chk("R7 clear after", '0);
    edge_clr = '0;
  endtask

  task automatic t_prev();
    sense_lvl = '1; polarity = '0; line_in = b(9); tick();
    chk("R10 level low", ~b(9));
    sense_lvl = '0; polarity = '1; edge_clr = '1; tick();
    chk("R10 no spurious edge", '0);
    edge_clr = '0; line_in = '0; tick();
    chk("R10 low", '0);
    line_in = b(9); tick();
    chk("R10 real edge", b(9));
  endtask

  task automatic t_mix();
    sense_lvl = b(0) | b(1);
    polarity  = ~(b(1) | b(3));
    dual_edge = b(4);
    line_in = b(3); edge_clr = '1; tick();
    chk("R12 setup", b(1));
    edge_clr = '0; line_in = b(0) | b(2); tick();
    chk("R12 step a", b(0) | b(1) | b(2) | b(3));
    line_in = b(1) | b(4); tick();
    chk("R12 step b", b(2) | b(3) | b(4));
  endtask

  initial begin
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_prio();
    t_prev();
    t_mix();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule